// File: doc/BRIEF.md
# DC-Free Differential Chip Spreader

This transmit-side baseband block turns a stream of data bits into a serial chip stream. Each accepted bit selects one of two fixed spreading symbols, `CHIPS` chips long. Every chip of the selected symbol is XORed with the chip most recently put on the output, and the result becomes the new output chip. This differential encoding lets a receiver recover the data from chip-to-chip phase changes alone, so it tolerates an offset in the oscillator frequency.

The encoder state is the last output chip. It is never cleared between symbols, so the first chip of a symbol is encoded against the last chip of the symbol before it. The two symbols are elaboration parameters. A designer picks them so that the encoded stream carries little energy near DC and has no chip pattern that repeats whatever the data.

Data enters through a valid/ready handshake. A chip slot recurs every `CYC_PER_CHIP` clock cycles. `in_ready` rises only in a slot cycle in which no chips of the current symbol remain to be sent. A bit accepted in that cycle has its first chip emitted in the same slot. A source that keeps `in_valid` high therefore gets a gapless chip stream, and it may hold `in_valid` low for as long as it likes. A slot that finds no data is a starved slot: it is flagged on `underflow`, and the output chip holds.

Top module: `dcfree_spreader`

## Requirements
- R1: `chip_stb` is a single-cycle pulse, one per emitted chip. Consecutive pulses are at least `CYC_PER_CHIP` cycles apart. While data is always available they are exactly `CYC_PER_CHIP` cycles apart.
- R2: Each emitted `chip_out` equals the current spreading chip XOR the previous `chip_out`. Spreading chips are taken leftmost (bit `CHIPS-1`) first. Between strobes `chip_out` does not change.
- R3: The encoder state carries across symbol boundaries. With `CHIPS`=4, symbol 1010 for data 0 and symbol 0111 for data 1, the following outputs are required. Data 0 yields 1100 from state 0 and 0011 from state 1. Data 1 yields 0101 from state 0 and 1010 from state 1.
- R4: A synchronous active-high `rst` clears `chip_out`, `chip_stb` and `underflow` to 0, sets the encoder state to 0 and discards any partly sent symbol. `in_ready` is low during reset.
- R5: `in_ready` is high only in a slot cycle in which no chips of the current symbol remain. If `in_valid` is high in that cycle, the bit is taken and its first chip is strobed in the following clock cycle.
- R6: `in_ready` does not depend on `in_valid`. `in_bit` has no effect on the output unless it is accepted by a handshake.
- R7: A slot that has no symbol in progress and no valid input is a starved slot. In it `underflow` pulses for one cycle, `chip_stb` stays low and `chip_out` holds. The encoder state is kept, so the next symbol continues from the last chip.
- R8: `in_bit`=0 selects parameter `SYM_ZERO` and `in_bit`=1 selects `SYM_ONE`, both `CHIPS` bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Data bit offered |
| in_ready | output | 1 | Block takes a bit in this cycle |
| in_bit | input | 1 | Data bit to spread |
| chip_out | output | 1 | Current encoded chip |
| chip_stb | output | 1 | Pulse marking a newly emitted chip |
| underflow | output | 1 | Pulse marking a starved chip slot |

## Verification
`in_ready` is combinational within the slot cycle. The strobe, the chip and the underflow flag that follow from that slot are registered and appear exactly one clock later. The bench runs a behavioural model that advances on each rising edge from the inputs it drove. It compares all four outputs on every falling edge, so each result is checked in the cycle it is due and never while it is changing. Stated chip groups are also collected from the strobes and compared whole after each symbol.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  // width needed to hold values 0..n-1 (at least one bit)
  function automatic int idx_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  typedef struct packed {
    logic stb;
    logic chip;
    logic starve;
  } chip_event_t;
endpackage

// File: rtl/dcs_chip_timer.sv
module dcs_chip_timer #(
  parameter int CYC_PER_CHIP = 2
) (
  input  logic clk,
  input  logic rst,
  output logic slot
);
  localparam int CW = dcs_pkg::idx_width(CYC_PER_CHIP);
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_CHIP - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign slot = (cnt == LAST) && !rst;
endmodule

// File: rtl/dcs_symbol_shifter.sv
module dcs_symbol_shifter #(
  parameter int CHIPS = 10,
  parameter logic [CHIPS-1:0] SYM_ZERO = '0,
  parameter logic [CHIPS-1:0] SYM_ONE  = '1
) (
  input  logic clk,
  input  logic rst,
  input  logic slot,
  input  logic load,
  input  logic data,
  output logic idle,
  output logic emit,
  output logic spread_chip
);
  localparam int LW = dcs_pkg::idx_width(CHIPS);
  localparam logic [LW-1:0] REFILL = LW'(CHIPS - 1);

  logic [CHIPS-1:0] sreg;
  logic [LW-1:0]    left;
  logic [CHIPS-1:0] chosen;

  assign chosen = data ? SYM_ONE : SYM_ZERO;
  assign idle   = (left == '0);
  assign emit   = slot && (!idle || load);
  assign spread_chip = idle ? chosen[CHIPS-1] : sreg[CHIPS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      left <= '0;
    end else if (slot) begin
      if (!idle) begin
        sreg <= {sreg[CHIPS-2:0], 1'b0};
        left <= left - 1'b1;
      end else if (load) begin
        sreg <= {chosen[CHIPS-2:0], 1'b0};
        left <= REFILL;
      end
    end
  end
endmodule

// File: rtl/dcs_diff_encoder.sv
module dcs_diff_encoder (
  input  logic clk,
  input  logic rst,
  input  logic emit,
  input  logic spread_chip,
  input  logic starve,
  output dcs_pkg::chip_event_t ev
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ev <= '0;
    end else begin
      ev.stb    <= emit;
      ev.starve <= starve;
      if (emit) ev.chip <= ev.chip ^ spread_chip;
    end
  end
endmodule

// File: rtl/dcfree_spreader.sv
module dcfree_spreader #(
  parameter int CHIPS = 10,
  parameter int CYC_PER_CHIP = 5,
  parameter logic [CHIPS-1:0] SYM_ZERO = 10'b1011010010,
  parameter logic [CHIPS-1:0] SYM_ONE  = 10'b0100101101
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic chip_out,
  output logic chip_stb,
  output logic underflow
);
  logic slot, idle, emit, spread_chip, accept, starve;
  dcs_pkg::chip_event_t ev;

  generate
    if (CHIPS < 2 || CYC_PER_CHIP < 2) begin : g_bad_cfg
      initial $display("dcfree_spreader: CHIPS and CYC_PER_CHIP must be at least 2");
    end
  endgenerate

  dcs_chip_timer #(.CYC_PER_CHIP(CYC_PER_CHIP)) u_timer (
    .clk(clk), .rst(rst), .slot(slot)
  );

  assign in_ready = slot && idle;
  assign accept   = in_ready && in_valid;
  assign starve   = in_ready && !in_valid;

  dcs_symbol_shifter #(.CHIPS(CHIPS), .SYM_ZERO(SYM_ZERO), .SYM_ONE(SYM_ONE)) u_shift (
    .clk(clk), .rst(rst), .slot(slot), .load(accept), .data(in_bit),
    .idle(idle), .emit(emit), .spread_chip(spread_chip)
  );

  dcs_diff_encoder u_enc (
    .clk(clk), .rst(rst), .emit(emit), .spread_chip(spread_chip),
    .starve(starve), .ev(ev)
  );

  assign chip_out  = ev.chip;
  assign chip_stb  = ev.stb;
  assign underflow = ev.starve;
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
  parameter int CYC_PER_CHIP = 5
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic chip_out,
  input logic chip_stb,
  input logic underflow
);
  logic [15:0] gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (chip_stb) begin
      gap  <= 16'd1;
      seen <= 1'b1;
    end else if (gap != 16'hFFFF) begin
      gap <= gap + 1'b1;
    end
  end

  assert_stb_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    chip_stb |=> !chip_stb);

  assert_stb_spacing_R1: assert property (@(posedge clk) disable iff (rst)
    (chip_stb && seen) |-> (gap >= 16'(CYC_PER_CHIP)));

  assert_hold_between_R2: assert property (@(posedge clk) disable iff (rst)
    !chip_stb |-> $stable(chip_out));

  assert_accept_emits_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> chip_stb);

  assert_ready_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (!chip_stb && !underflow));

  assert_starve_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> (underflow && !chip_stb));

  assert_starve_hold_R7: assert property (@(posedge clk) disable iff (rst)
    underflow |-> $stable(chip_out));
endmodule

bind dcfree_spreader dcs_checker #(.CYC_PER_CHIP(CYC_PER_CHIP)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .chip_out(chip_out), .chip_stb(chip_stb), .underflow(underflow)
);

// File: tb/sim_dcfree_spreader.sv
module sim_dcfree_spreader;
  localparam int CH  = 4;
  localparam int CYC = 2;
  localparam logic [CH-1:0] S0 = 4'b1010;
  localparam logic [CH-1:0] S1 = 4'b0111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_ready, chip_out, chip_stb, underflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dcfree_spreader #(.CHIPS(CH), .CYC_PER_CHIP(CYC), .SYM_ZERO(S0), .SYM_ONE(S1)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .chip_out(chip_out), .chip_stb(chip_stb), .underflow(underflow)
  );

  // behavioural reference
  int phase = 0;
  bit pend[$];
  bit m_chip = 0, m_stb = 0, m_unf = 0;
  bit got[$];

  function automatic bit m_ready();
    return !rst && (phase == CYC - 1) && (pend.size() == 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      phase = 0; pend.delete(); m_chip = 0; m_stb = 0; m_unf = 0;
    end else begin
      m_stb = 0; m_unf = 0;
      if (phase == CYC - 1) begin
        if (pend.size() == 0 && in_valid) begin
          for (int i = CH - 1; i >= 0; i--) pend.push_back(in_bit ? S1[i] : S0[i]);
        end
        if (pend.size() != 0) begin
          m_chip = m_chip ^ pend.pop_front();
          m_stb = 1;
        end else begin
          m_unf = 1;
        end
        phase = 0;
      end else begin
        phase = phase + 1;
      end
    end
  end

  task automatic chk(input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(chip_out, m_chip, "R2 chip_out");
      chk(chip_stb, m_stb, "R1 chip_stb");
      chk(underflow, m_unf, "R7 underflow");
      chk(in_ready, m_ready(), "R5 in_ready");
      if (chip_stb) got.push_back(chip_out);
    end
  end

  task automatic send_bit(input bit b);
    in_valid = 1'b1; in_bit = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    in_valid = 1'b0;
    while (!in_ready) @(negedge clk);
  endtask

  task automatic expect_group(input logic [CH-1:0] exp, input string tag);
    logic [CH-1:0] v;
    v = '0;
    checks++;
    if (got.size() < CH) begin
      errors++;
      $display("FAIL %s actual=only %0d chips expected=%b", tag, got.size(), exp);
      got.delete();
    end else begin
      for (int i = CH - 1; i >= 0; i--) v[i] = got.pop_front();
      if (v !== exp) begin
        errors++;
        $display("FAIL %s actual=%b expected=%b", tag, v, exp);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R4: state during reset
    checks++;
    if (chip_out !== 0 || chip_stb !== 0 || underflow !== 0 || in_ready !== 0) begin
      errors++;
      $display("FAIL R4 reset outputs actual=%b%b%b%b expected=0000",
               chip_out, chip_stb, underflow, in_ready);
    end
    rst = 1'b0;
    @(negedge clk);
    // R3/R8: gapless 0,1,0,1 from state 0
    send_bit(0); send_bit(1); send_bit(0); send_bit(1);
    drain();
    @(negedge clk);
    expect_group(4'b1100, "R3 data0 from state0");
    expect_group(4'b0101, "R3 data1 from state0");
    expect_group(4'b0011, "R3 data0 from state1");
    expect_group(4'b1010, "R3 data1 from state1");
    // R7: starve several slots while toggling in_bit (R6: ignored)
    for (int k = 0; k < 8; k++) begin in_bit = ~in_bit; @(negedge clk); end
    checks++;
    if (got.size() != 0) begin
      errors++;
      $display("FAIL R6 chips while idle actual=%0d expected=0", got.size());
      got.delete();
    end
    // R7: state kept (last chip 0) across starvation
    send_bit(1); send_bit(0);
    drain(); @(negedge clk);
    expect_group(4'b0101, "R7 data1 after starve");
    expect_group(4'b0011, "R7 data0 continues from state1");
    // R4: reset in the middle of a symbol
    send_bit(1);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    got.delete();
    send_bit(0);
    drain(); @(negedge clk);
    expect_group(4'b1100, "R4 data0 after mid reset");
    // mixed gapless run checked by the model
    for (int k = 0; k < 40; k++) send_bit(((k * 7) % 5) > 1);
    drain();
    repeat (6) @(negedge clk);
    got.delete();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule